// File: doc/BRIEF.md
# Clock Power-Down and Wakeup Controller

This block sequences the power modes of a small microcontroller core. Software writes a clock-control register whose freeze bit, primary-oscillator-off bit and secondary-oscillator-on bit together pick a low-power state. The block turns those bits into clock enables for the primary oscillator, the secondary oscillator, a timer, the CPU and a multiplier unit. It also drives a freeze flag that leaves the chip on a pin so that external circuits can power down with the core.

Three wake inputs arrive asynchronously: an I/O event, an audio-detect event and a timer overflow. Each passes through a two-flop synchronizer and a rising-edge detector on the always-running controller clock. The wake sources that are accepted depend on which oscillator stays on. In deep sleep only the I/O event is accepted. In idle, and in a light state where the primary oscillator keeps running, any source is accepted. A wakeup clears the freeze and oscillator-off bits in hardware. It then holds the CPU clock off for a programmable settle count, and it records which sources caused the wakeup in a status register that clears when software reads it.

Top module: `pwr_mode_ctl`

## Requirements
- R1: After reset the clock-control register reads 0x00, the extended clock register reads 0x10, the settle register reads SETTLE_RESET (default 8) and the wake status reads 0x00. cpu_clk_en, pri_osc_en, tmr_clk_en and mul_clk_en are 1, and sec_osc_en and pdn_pin are 0.
- R2: Registers are written with reg_wr and read back on reg_rdata with no clock delay (combinational). The clock-control register is at 0xE8, with freeze in bit 7, primary-oscillator-off in bit 0 and secondary-oscillator-on in bit 1. The extended clock register is at 0xD6, with the multiplier clock enable in bit 4. The settle count is at 0xE9. The wake status is at 0xEA, with I/O in bit 0, audio in bit 1 and timer in bit 2. Unused bits and unmapped addresses read 0.
- R3: pdn_pin always equals the freeze bit, and cpu_clk_en is 0 whenever the freeze bit is 1.
- R4: Sleep (freeze=1, off=1, on=0) drives pri_osc_en, sec_osc_en and tmr_clk_en to 0. Only an I/O edge ends Sleep. Audio and timer edges leave the block asleep.
- R5: Idle (freeze=1, off=1, on=1) drives pri_osc_en to 0 and keeps sec_osc_en and tmr_clk_en at 1. An I/O, audio or timer edge ends Idle.
- R6: With freeze=1 and off=0, pri_osc_en stays 1 and any of the three sources ends power-down.
- R7: Each wake input is synchronized by two flops and acts on its rising edge. The wakeup takes effect at the third rising clock edge after the input goes high. A level held high wakes the core at most once.
- R8: A wakeup clears the freeze and off bits and keeps the on bit. cpu_clk_en then stays 0 for exactly the settle-register value in cycles. A value of 0 releases the CPU clock on the wakeup edge.
- R9: A wake edge that reaches the controller in the same cycle as the write that sets freeze is honoured: freeze is never set, and the status and settle count apply as for any wakeup.
- R10: A wakeup loads the wake status with the bits of all accepted sources of that wakeup and replaces the previous contents. A reg_rd of 0xEA clears the status on the next edge.
- R11: Register writes and status-clearing reads have no effect while cpu_clk_en is 0.
- R12: mul_clk_en follows bit 4 of the extended clock register and does not depend on the power mode.
- R13: Wake edges that arrive while freeze is 0 do not change the wake status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears the wake status at 0xEA) |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| io_wake | input | 1 | Asynchronous I/O wake event |
| audio_wake | input | 1 | Asynchronous audio-detect wake event |
| tmr_ovf | input | 1 | Asynchronous timer overflow request |
| pri_osc_en | output | 1 | Primary oscillator enable |
| sec_osc_en | output | 1 | Secondary oscillator enable |
| tmr_clk_en | output | 1 | Timer clock enable |
| cpu_clk_en | output | 1 | CPU clock enable |
| mul_clk_en | output | 1 | Multiplier unit clock enable |
| pdn_pin | output | 1 | Processor freeze flag for the external pin |

## Verification
The hardest case is a wake edge that lands on the same clock edge as the register write that sets the freeze bit, because the synchronizer hides the input for two cycles. The bench raises io_wake exactly two falling edges before it issues the write, so the detected edge and the write meet at one rising edge. It then checks that pdn_pin never rises while the settle gate and the status still act. A behavioural model that keeps the wake-input history in a queue predicts every output and the read data on every cycle. Directed checks cover held-high inputs, sources that Sleep rejects and a settle count of zero.

// File: rtl/pwr_mode_ctl.sv
module pwr_mode_ctl #(
  parameter int SETTLE_W     = 8,
  parameter int SETTLE_RESET = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       io_wake,
  input  logic       audio_wake,
  input  logic       tmr_ovf,
  output logic       pri_osc_en,
  output logic       sec_osc_en,
  output logic       tmr_clk_en,
  output logic       cpu_clk_en,
  output logic       mul_clk_en,
  output logic       pdn_pin
);

  localparam logic [7:0] ADDR_CK  = 8'hE8;
  localparam logic [7:0] ADDR_EXT = 8'hD6;
  localparam logic [7:0] ADDR_SET = 8'hE9;
  localparam logic [7:0] ADDR_WST = 8'hEA;
  localparam logic [SETTLE_W-1:0] CNT_ONE = {{(SETTLE_W-1){1'b0}}, 1'b1};
  localparam logic [SETTLE_W-1:0] CNT_ZERO = '0;

  logic                pd_q, poff_q, son_q, mul_q;
  logic [SETTLE_W-1:0] settle_q, cnt_q;
  logic [2:0]          wst_q;
  logic [2:0]          sy1_q, sy2_q, sy3_q;

  logic       run, ck_wr, rd_clr, eff_pd, eff_poff, eff_son, wake;
  logic [2:0] rise, hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy1_q <= '0;
      sy2_q <= '0;
      sy3_q <= '0;
    end else begin
      sy1_q <= {tmr_ovf, audio_wake, io_wake};
      sy2_q <= sy1_q;
      sy3_q <= sy2_q;
    end
  end

  assign rise   = sy2_q & ~sy3_q;
  assign run    = !pd_q && (cnt_q == CNT_ZERO);
  assign ck_wr  = reg_wr && run && (reg_addr == ADDR_CK);
  assign rd_clr = reg_rd && run && (reg_addr == ADDR_WST);

  assign eff_pd   = ck_wr ? reg_wdata[7] : pd_q;
  assign eff_poff = ck_wr ? reg_wdata[0] : poff_q;
  assign eff_son  = ck_wr ? reg_wdata[1] : son_q;

  assign hit  = !eff_pd ? 3'b000 :
                (eff_poff && !eff_son) ? (rise & 3'b001) : rise;
  assign wake = |hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_q   <= 1'b0;
      poff_q <= 1'b0;
      son_q  <= 1'b0;
      cnt_q  <= '0;
      wst_q  <= '0;
    end else if (wake) begin
      pd_q   <= 1'b0;
      poff_q <= 1'b0;
      son_q  <= eff_son;
      cnt_q  <= settle_q;
      wst_q  <= hit;
    end else begin
      if (ck_wr) begin
        pd_q   <= reg_wdata[7];
        poff_q <= reg_wdata[0];
        son_q  <= reg_wdata[1];
      end
      if (cnt_q != CNT_ZERO) cnt_q <= cnt_q - CNT_ONE;
      if (rd_clr) wst_q <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mul_q    <= 1'b1;
      settle_q <= SETTLE_W'(SETTLE_RESET);
    end else begin
      if (reg_wr && run && reg_addr == ADDR_EXT) mul_q <= reg_wdata[4];
      if (reg_wr && run && reg_addr == ADDR_SET) settle_q <= SETTLE_W'(reg_wdata);
    end
  end

  always_comb begin
    case (reg_addr)
      ADDR_CK:  reg_rdata = {pd_q, 5'b0, son_q, poff_q};
      ADDR_EXT: reg_rdata = {3'b0, mul_q, 4'b0};
      ADDR_SET: reg_rdata = 8'(settle_q);
      ADDR_WST: reg_rdata = {5'b0, wst_q};
      default:  reg_rdata = 8'h00;
    endcase
  end

  assign pri_osc_en = !(pd_q && poff_q);
  assign sec_osc_en = son_q;
  assign tmr_clk_en = !(pd_q && poff_q && !son_q);
  assign cpu_clk_en = run;
  assign mul_clk_en = mul_q;
  assign pdn_pin    = pd_q;

endmodule

// File: rtl/pwr_mode_ctl_chk.sv
module pwr_mode_ctl_chk #(
  parameter int SETTLE_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                reg_wr,
  input logic                reg_rd,
  input logic [7:0]          reg_addr,
  input logic                wd7,
  input logic                pri_osc_en,
  input logic                sec_osc_en,
  input logic                tmr_clk_en,
  input logic                cpu_clk_en,
  input logic                mul_clk_en,
  input logic                pdn_pin,
  input logic [2:0]          wst,
  input logic [SETTLE_W-1:0] cnt
);

  // R3
  freeze_gates_cpu_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pdn_pin |-> !cpu_clk_en);

  // R8
  settle_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |-> !cpu_clk_en);

  // R8
  wake_restarts_osc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pdn_pin) |-> pri_osc_en);

  // R4
  sleep_stops_timer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pdn_pin && !pri_osc_en && !sec_osc_en) |-> !tmr_clk_en);

  // R5
  idle_keeps_timer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pdn_pin && sec_osc_en) |-> tmr_clk_en);

  // R11
  frozen_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_clk_en && reg_wr && reg_addr == 8'hD6) |=> $stable(mul_clk_en));

  // R12
  mul_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mul_clk_en) |-> $past(reg_wr && reg_addr == 8'hD6));

  // R13
  status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pdn_pin && !(reg_rd && reg_addr == 8'hEA) && !(reg_wr && reg_addr == 8'hE8 && wd7))
      |=> $stable(wst));

endmodule

bind pwr_mode_ctl pwr_mode_ctl_chk #(.SETTLE_W(SETTLE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_wr     (reg_wr),
  .reg_rd     (reg_rd),
  .reg_addr   (reg_addr),
  .wd7        (reg_wdata[7]),
  .pri_osc_en (pri_osc_en),
  .sec_osc_en (sec_osc_en),
  .tmr_clk_en (tmr_clk_en),
  .cpu_clk_en (cpu_clk_en),
  .mul_clk_en (mul_clk_en),
  .pdn_pin    (pdn_pin),
  .wst        (wst_q),
  .cnt        (cnt_q)
);

// File: tb/pwr_mode_ctl_tb.sv
module pwr_mode_ctl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SRST = 8;

  logic clk = 0, rst_n = 0, reg_wr = 0, reg_rd = 0;
  logic [7:0] reg_addr = 0, reg_wdata = 0;
  logic io_wake = 0, audio_wake = 0, tmr_ovf = 0;
  logic [7:0] reg_rdata;
  logic pri_osc_en, sec_osc_en, tmr_clk_en, cpu_clk_en, mul_clk_en, pdn_pin;

  pwr_mode_ctl #(.SETTLE_W(8), .SETTLE_RESET(SRST)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .io_wake(io_wake), .audio_wake(audio_wake), .tmr_ovf(tmr_ovf),
    .pri_osc_en(pri_osc_en), .sec_osc_en(sec_osc_en), .tmr_clk_en(tmr_clk_en),
    .cpu_clk_en(cpu_clk_en), .mul_clk_en(mul_clk_en), .pdn_pin(pdn_pin));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  string cur = "R1";

  // behavioural reference state
  bit m_pd, m_poff, m_son, m_mul;
  int m_settle, m_cnt;
  bit [2:0] m_wst;
  bit [2:0] hist[$];

  always @(posedge clk or negedge rst_n) begin
    bit run, ckw, epd, epoff, eson;
    bit [2:0] edg, hit;
    if (!rst_n) begin
      m_pd = 0; m_poff = 0; m_son = 0; m_mul = 1;
      m_settle = SRST; m_cnt = 0; m_wst = 0;
      hist = '{3'b0, 3'b0, 3'b0};
    end else begin
      run   = !m_pd && m_cnt == 0;
      ckw   = reg_wr && run && reg_addr == 8'hE8;
      epd   = ckw ? reg_wdata[7] : m_pd;
      epoff = ckw ? reg_wdata[0] : m_poff;
      eson  = ckw ? reg_wdata[1] : m_son;
      edg   = hist[1] & ~hist[2];
      hit   = 0;
      if (epd) hit = (epoff && !eson) ? (edg & 3'b001) : edg;
      if (hit != 0) begin
        m_pd = 0; m_poff = 0; m_son = eson; m_cnt = m_settle; m_wst = hit;
      end else begin
        if (ckw) begin m_pd = reg_wdata[7]; m_poff = reg_wdata[0]; m_son = reg_wdata[1]; end
        if (m_cnt > 0) m_cnt--;
        if (reg_rd && run && reg_addr == 8'hEA) m_wst = 0;
      end
      if (reg_wr && run && reg_addr == 8'hD6) m_mul = reg_wdata[4];
      if (reg_wr && run && reg_addr == 8'hE9) m_settle = int'(reg_wdata);
      hist.push_front({tmr_ovf, audio_wake, io_wake});
      void'(hist.pop_back());
    end
  end

  function automatic logic [7:0] exp_rd(logic [7:0] a);
    case (a)
      8'hE8:   return {m_pd, 5'b0, m_son, m_poff};
      8'hD6:   return {3'b0, m_mul, 4'b0};
      8'hE9:   return 8'(m_settle);
      8'hEA:   return {5'b0, m_wst};
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(string what, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual %0h expected %0h", cur, what, act, exp);
    end
  endtask

  task automatic tick;
    @(negedge clk);
    chk("R2 rdata", reg_rdata, exp_rd(reg_addr));
    chk("R3 pdn_pin", pdn_pin, m_pd);
    chk("R8 cpu_clk_en", cpu_clk_en, !m_pd && m_cnt == 0);
    chk("R6 pri_osc_en", pri_osc_en, !(m_pd && m_poff));
    chk("R5 sec_osc_en", sec_osc_en, m_son);
    chk("R4 tmr_clk_en", tmr_clk_en, !(m_pd && m_poff && !m_son));
    chk("R12 mul_clk_en", mul_clk_en, m_mul);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    tick();
    reg_wr = 0;
  endtask

  task automatic rd_clear;
    reg_addr = 8'hEA; reg_rd = 1;
    tick();
    reg_rd = 0;
  endtask

  task automatic peek(string what, logic [7:0] a, logic [7:0] exp);
    reg_addr = a;
    #1;
    chk(what, reg_rdata, exp);
  endtask

  task automatic finish_run;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog all requirements actual hung expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    cur = "R1";
    chk("R1 cpu_clk_en", cpu_clk_en, 1);
    chk("R1 pri_osc_en", pri_osc_en, 1);
    chk("R1 sec_osc_en", sec_osc_en, 0);
    chk("R1 tmr_clk_en", tmr_clk_en, 1);
    chk("R1 mul_clk_en", mul_clk_en, 1);
    chk("R1 pdn_pin", pdn_pin, 0);
    peek("R1 ckctl", 8'hE8, 8'h00);
    peek("R1 ext", 8'hD6, 8'h10);
    peek("R1 settle", 8'hE9, 8'(SRST));
    peek("R1 status", 8'hEA, 8'h00);
    tick();

    // R2 and R12 register access
    cur = "R2";
    wr(8'hE8, 8'h7E);
    peek("R2 ckctl unused bits", 8'hE8, 8'h02);
    chk("R2 sec_osc_en", sec_osc_en, 1);
    cur = "R12";
    wr(8'hD6, 8'hEF);
    chk("R12 mul off", mul_clk_en, 0);
    peek("R12 ext", 8'hD6, 8'h00);
    wr(8'hD6, 8'h10);
    cur = "R2";
    wr(8'hE9, 8'h04);
    peek("R2 settle", 8'hE9, 8'h04);
    peek("R2 unmapped", 8'h33, 8'h00);
    wr(8'hE8, 8'h00);

    // R6 freeze with primary running, audio wake; R7 latency, R8 settle
    cur = "R6";
    wr(8'hE8, 8'h80);
    chk("R6 pdn", pdn_pin, 1);
    chk("R6 pri on", pri_osc_en, 1);
    chk("R3 cpu gated", cpu_clk_en, 0);
    audio_wake = 1;
    ticks(2);
    cur = "R7";
    chk("R7 still frozen after two edges", pdn_pin, 1);
    tick();
    chk("R7 woken at third edge", pdn_pin, 0);
    cur = "R8";
    ticks(3);
    chk("R8 cpu gated during settle", cpu_clk_en, 0);
    tick();
    chk("R8 cpu released after settle", cpu_clk_en, 1);
    peek("R10 audio status", 8'hEA, 8'h02);
    audio_wake = 0;
    cur = "R10";
    rd_clear();
    peek("R10 cleared by read", 8'hEA, 8'h00);

    // R13 edges while running
    cur = "R13";
    io_wake = 1;
    ticks(5);
    io_wake = 0;
    ticks(3);
    peek("R13 status untouched", 8'hEA, 8'h00);

    // R4 sleep rejects audio and timer
    cur = "R4";
    wr(8'hE8, 8'h81);
    chk("R4 pri off", pri_osc_en, 0);
    chk("R4 sec off", sec_osc_en, 0);
    chk("R4 tmr off", tmr_clk_en, 0);
    audio_wake = 1; tmr_ovf = 1;
    ticks(2);
    audio_wake = 0; tmr_ovf = 0;
    ticks(6);
    chk("R4 still asleep", pdn_pin, 1);
    // R11 writes ignored while frozen
    cur = "R11";
    wr(8'hD6, 8'h00);
    chk("R11 mul unchanged", mul_clk_en, 1);
    peek("R11 ext unchanged", 8'hD6, 8'h10);
    cur = "R4";
    io_wake = 1;
    ticks(3);
    chk("R4 io wakes sleep", pdn_pin, 0);
    chk("R8 primary back on", pri_osc_en, 1);
    ticks(10);
    peek("R8 ckctl cleared", 8'hE8, 8'h00);
    peek("R10 io status", 8'hEA, 8'h01);

    // R7 held-high input wakes only once
    cur = "R7";
    wr(8'hE8, 8'h81);
    ticks(8);
    chk("R7 held level ignored", pdn_pin, 1);
    io_wake = 0;
    ticks(2);
    io_wake = 1;
    ticks(3);
    chk("R7 new edge wakes", pdn_pin, 0);
    ticks(10);
    io_wake = 0;
    ticks(3);

    // R5 idle, timer wake, secondary kept
    cur = "R5";
    wr(8'hE8, 8'h83);
    chk("R5 pri off", pri_osc_en, 0);
    chk("R5 sec on", sec_osc_en, 1);
    chk("R5 tmr on", tmr_clk_en, 1);
    tmr_ovf = 1;
    ticks(3);
    chk("R5 timer wakes idle", pdn_pin, 0);
    chk("R8 secondary kept", sec_osc_en, 1);
    ticks(10);
    tmr_ovf = 0;
    peek("R8 ckctl keeps on bit", 8'hE8, 8'h02);
    peek("R10 timer status", 8'hEA, 8'h04);

    // R10 simultaneous sources, then replacement
    cur = "R10";
    ticks(3);
    wr(8'hE8, 8'h83);
    io_wake = 1; audio_wake = 1; tmr_ovf = 1;
    ticks(3);
    ticks(10);
    peek("R10 all sources", 8'hEA, 8'h07);
    io_wake = 0; audio_wake = 0; tmr_ovf = 0;
    ticks(3);
    wr(8'hE8, 8'h81);
    io_wake = 1;
    ticks(13);
    peek("R10 replaced by last", 8'hEA, 8'h01);
    io_wake = 0;
    ticks(3);
    rd_clear();

    // R9 wake edge coincides with the freeze write
    cur = "R9";
    io_wake = 1;
    ticks(2);
    wr(8'hE8, 8'h81);
    chk("R9 freeze never set", pdn_pin, 0);
    chk("R9 settle applies", cpu_clk_en, 0);
    peek("R9 status", 8'hEA, 8'h01);
    ticks(6);
    chk("R9 cpu released", cpu_clk_en, 1);
    peek("R9 ckctl", 8'hE8, 8'h00);
    io_wake = 0;
    ticks(3);

    // R8 zero settle count
    cur = "R8";
    wr(8'hE9, 8'h00);
    wr(8'hE8, 8'h80);
    audio_wake = 1;
    ticks(3);
    chk("R8 zero settle pdn", pdn_pin, 0);
    chk("R8 zero settle cpu", cpu_clk_en, 1);
    audio_wake = 0;
    ticks(5);

    finish_run();
  end
endmodule